// File: doc/BRIEF.md
# Eight-Stage Parallel-Load Shift Register

This block is an eight-stage shift register that can be filled in two ways. When its mode input is low, each rising clock edge pushes one bit from the serial input into the first stage and advances every other stage by one place. When the mode input is high, all eight stages take their values from eight parallel inputs. The register is read through three taps: stages six and seven, and stage eight, which is the main serial output.

A build-time parameter sets how a parallel load is timed. In the edge variant the load happens on the rising clock edge. In the level variant the taps follow the parallel inputs as soon as the mode input goes high, with no clock edge needed, and the clock has no visible effect while the mode input stays high. Longer chains are built by feeding the stage-eight tap of one instance into the serial input of the next, with the clock and mode input shared.

Typical uses are parallel-to-serial conversion and queueing a parallel word out bit by bit. A synchronous active-high reset clears the register.

Top module: `pload_shreg8`

## Requirements
- R1: While `rst` is high at a rising edge, all eight stages clear to zero, taking priority over shifting and loading. With `shift_ld` low after that edge, all three taps read 0.
- R2: With `shift_ld` low (0 = shift), a rising edge moves `ser_in` into stage 1 and stage n into stage n+1 for n = 1 to 7.
- R3: Edge variant (`LOAD_TIMING` = `LOAD_ON_EDGE`): with `shift_ld` high (1 = load), a rising edge loads stage k from `par_in[k-1]`. Raising `shift_ld` or changing `par_in` between edges leaves the taps unchanged.
- R4: Level variant (`LOAD_TIMING` = `LOAD_LEVEL`): while `shift_ld` is high, the taps show `par_in[5]`, `par_in[6]` and `par_in[7]` without waiting for a clock edge. They follow changes to `par_in` between edges, and clock edges cause no other change.
- R5: Level variant: once `shift_ld` falls, the taps hold the values last loaded, and the next rising edge shifts starting from them.
- R6: `tap_s6`, `tap_s7` and `tap_s8` show stages 6, 7 and 8. On a shift edge, `tap_s7` takes the previous value of `tap_s6` and `tap_s8` takes the previous value of `tap_s7`.
- R7: After a load, `tap_s8` shows `par_in[7]`. After each of the next seven shift edges it shows, in turn, `par_in[6]`, `par_in[5]` and so on down to `par_in[0]`.
- R8: When `tap_s8` of one instance drives `ser_in` of a second instance, with clock and mode shared, eight shift edges after a load move the first instance's loaded word into the second instance, stage for stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifts and edge loads happen on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all stages |
| shift_ld | input | 1 | Mode select: 0 = shift, 1 = parallel load |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | 8 | Parallel load word; bit k-1 feeds stage k |
| tap_s6 | output | 1 | Stage 6 value |
| tap_s7 | output | 1 | Stage 7 value |
| tap_s8 | output | 1 | Stage 8 value, the serial output |

## Verification
The assertions assume that `rst` is driven from time zero. In the level variant they also assume that `par_in` does not change between the last rising edge before `shift_ld` falls and the fall itself, so the stored stages match what the taps showed. The stimulus changes inputs on falling clock edges. The deliberate mid-cycle changes to `shift_ld` and `par_in` are made early enough that a rising edge always comes after the last change to `par_in` and before `shift_ld` is lowered. This keeps the level-variant stored word equal to the displayed one.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Timing of a parallel load
  typedef enum logic {
    LOAD_ON_EDGE = 1'b0,
    LOAD_LEVEL   = 1'b1
  } load_timing_e;

  localparam int DEF_STAGES = 8;

endpackage

// File: rtl/psr_stage.sv
// One storage cell: clear, parallel capture, or serial capture on the rising edge.
module psr_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic ser_d,
  input  logic par_d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= par_d;
    else           q <= ser_d;
  end

endmodule

// File: rtl/psr_view.sv
// Chooses what the taps see: the stored word, or in the level variant the live
// parallel word while a load is requested.
module psr_view import psr_pkg::*; #(
  parameter int           W      = DEF_STAGES,
  parameter load_timing_e TIMING = LOAD_ON_EDGE
) (
  input  logic [W-1:0] held,
  input  logic [W-1:0] par,
  input  logic         load,
  output logic [W-1:0] seen
);

  localparam logic LEVEL_ON = (TIMING == LOAD_LEVEL);

  logic bypass;

  assign bypass = LEVEL_ON & load;

  always_comb begin
    seen = bypass ? par : held;
  end

endmodule

// File: rtl/pload_shreg8.sv
module pload_shreg8 import psr_pkg::*; #(
  parameter int           STAGES      = DEF_STAGES,
  parameter int           TAP_LO      = 6,
  parameter int           TAP_MID     = 7,
  parameter load_timing_e LOAD_TIMING = LOAD_ON_EDGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_ld,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              tap_s6,
  output logic              tap_s7,
  output logic              tap_s8
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] seen;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign chain_d[gi] = ser_in;
      end else begin : g_body
        assign chain_d[gi] = stage_q[gi-1];
      end
      psr_stage u_cell (
        .clk   (clk),
        .rst   (rst),
        .load  (shift_ld),
        .ser_d (chain_d[gi]),
        .par_d (par_in[gi]),
        .q     (stage_q[gi])
      );
    end
  endgenerate

  psr_view #(
    .W      (STAGES),
    .TIMING (LOAD_TIMING)
  ) u_view (
    .held (stage_q),
    .par  (par_in),
    .load (shift_ld),
    .seen (seen)
  );

  assign tap_s6 = seen[TAP_LO-1];
  assign tap_s7 = seen[TAP_MID-1];
  assign tap_s8 = seen[LAST];

endmodule

// File: rtl/psr_chk.sv
module psr_chk import psr_pkg::*; #(
  parameter int           STAGES      = DEF_STAGES,
  parameter int           TAP_LO      = 6,
  parameter load_timing_e LOAD_TIMING = LOAD_ON_EDGE
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_ld,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic [STAGES-1:0] stage_q,
  input logic              tap_s6,
  input logic              tap_s7,
  input logic              tap_s8
);

  logic armed = 1'b0;

  always_ff @(posedge clk) armed <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (stage_q == '0)); // R1

  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    !shift_ld |=> (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)})); // R2

  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    shift_ld |=> (stage_q == $past(par_in))); // R3

  AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !shift_ld |=> (shift_ld || (tap_s7 == $past(tap_s6) && tap_s8 == $past(tap_s7)))); // R6

  generate
    if (LOAD_TIMING == LOAD_LEVEL) begin : g_level
      AST_LEVEL_SHOWS_PAR: assert property (@(posedge clk) disable iff (rst)
        shift_ld |-> (tap_s8 == par_in[STAGES-1] && tap_s6 == par_in[TAP_LO-1])); // R4
    end
  endgenerate

endmodule

bind pload_shreg8 psr_chk #(
  .STAGES      (STAGES),
  .TAP_LO      (TAP_LO),
  .LOAD_TIMING (LOAD_TIMING)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_ld (shift_ld),
  .ser_in   (ser_in),
  .par_in   (par_in),
  .stage_q  (stage_q),
  .tap_s6   (tap_s6),
  .tap_s7   (tap_s7),
  .tap_s8   (tap_s8)
);

// File: tb/sim_pload_shreg8.sv
`timescale 1ns/100ps
module sim_pload_shreg8;
  import psr_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld  = 1'b0;
  logic       ser = 1'b0;
  logic [7:0] par = 8'h00;
  logic [7:0] par2 = 8'h00;

  logic e6, e7, e8, l6, l7, l8, c6, c7, c8;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  pload_shreg8 #(.LOAD_TIMING(LOAD_ON_EDGE)) u0 (
    .clk(clk), .rst(rst), .shift_ld(ld), .ser_in(ser), .par_in(par),
    .tap_s6(e6), .tap_s7(e7), .tap_s8(e8));

  pload_shreg8 #(.LOAD_TIMING(LOAD_LEVEL)) u1 (
    .clk(clk), .rst(rst), .shift_ld(ld), .ser_in(ser), .par_in(par),
    .tap_s6(l6), .tap_s7(l7), .tap_s8(l8));

  // Second stage of an R8 cascade, fed by u0's serial output
  pload_shreg8 #(.LOAD_TIMING(LOAD_ON_EDGE)) u2 (
    .clk(clk), .rst(rst), .shift_ld(ld), .ser_in(e8), .par_in(par2),
    .tap_s6(c6), .tap_s7(c7), .tap_s8(c8));

  // {rst, ld, ser, par}
  localparam logic [10:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'h0F},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h81},
    {1'b0, 1'b0, 1'b0, 8'h81}
  };

  function automatic logic [2:0] expect_taps(input bit level);
    logic [7:0] v;
    v = (level && ld) ? par : model;
    return {v[7], v[6], v[5]};
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: taps(s8,s7,s6) got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic r, input logic l, input logic s, input logic [7:0] p);
    @(negedge clk);
    rst = r; ld = l; ser = s; par = p;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst)     model = 8'h00;
    else if (ld) model = par;
    else         model = {model[6:0], ser};
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    check("R1 reset state edge variant", {e8, e7, e6}, 3'b000);
    check("R1 reset state level variant", {l8, l7, l6}, 3'b000);

    // Table walk: R1 R2 R3 R6 against the model
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
      step();
      check("R2/R3/R6 table edge variant", {e8, e7, e6}, expect_taps(1'b0));
      check("R2/R3/R4 table level variant", {l8, l7, l6}, expect_taps(1'b1));
    end

    // R7 drain order and R8 cascade
    par2 = 8'h00;
    drive(1'b0, 1'b1, 1'b0, 8'hC6);
    step();
    check("R7 load shows par[7]", {e8, 1'b0, 1'b0}, {1'b1, 1'b0, 1'b0});
    for (int j = 1; j < 8; j++) begin
      drive(1'b0, 1'b0, 1'b0, 8'hC6);
      step();
      check($sformatf("R7 drain step %0d", j), {e8, 2'b00}, {par[7-j], 2'b00});
    end
    drive(1'b0, 1'b0, 1'b0, 8'hC6);
    step();
    check("R8 cascade word in second instance", {c8, c7, c6}, {1'b1, 1'b1, 1'b0});

    // Mid-cycle mode change: R3, R4, R5
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    step();
    @(negedge clk);
    ld = 1'b1; par = 8'h5A;
    #0.5;
    check("R4 level taps follow par without clock", {l8, l7, l6}, 3'b010);
    check("R3 edge taps unchanged before edge", {e8, e7, e6}, expect_taps(1'b0));
    #0.5;
    par = 8'hA3;
    #0.5;
    check("R4 level taps follow par change", {l8, l7, l6}, 3'b101);
    check("R3 edge taps ignore par change", {e8, e7, e6}, expect_taps(1'b0));
    step();
    check("R3 edge load on edge", {e8, e7, e6}, 3'b101);
    check("R4 level taps after edge", {l8, l7, l6}, 3'b101);
    @(negedge clk);
    ld = 1'b0;
    #0.5;
    check("R5 level holds loaded word after fall", {l8, l7, l6}, 3'b101);
    ser = 1'b1;
    step();
    check("R5 level shift from loaded word", {l8, l7, l6}, expect_taps(1'b1));
    check("R5 level shift value", {l8, l7, l6}, 3'b010);
    check("R2 edge shift value", {e8, e7, e6}, 3'b010);

    // R1 reset priority over load, level variant with control low afterwards
    drive(1'b1, 1'b1, 1'b1, 8'hFF);
    step();
    drive(1'b0, 1'b0, 1'b0, 8'hFF);
    #0.5;
    check("R1 reset beats load edge variant", {e8, e7, e6}, 3'b000);
    check("R1 reset beats load level variant", {l8, l7, l6}, 3'b000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule